// File: doc/BRIEF.md
# Link-Pulse Energy Detector

This block produces the energy-on flag that wakes an Ethernet PHY from its energy-detect power-down mode. It watches a digitised normal-link-pulse input and qualifies it with two state machines. The qualifier machine declares signal-valid only when a second pulse edge follows a first one inside a fixed window, after the line has gone low and a short guard time has passed. The energy machine raises energy-on whenever signal-valid fires. It drops energy-on after a sustained drop period. With auto-negotiation enabled, that period is time spent in the auto-negotiation detection state. With auto-negotiation disabled, it is time without link.

All time constants are counted in ticks of a prescaler running from the system clock. One tick is meant to be 1 us. The guard time (2 us), the qualifying window (64 ms) and the drop period (256 ms) are parameters expressed in ticks. A link partner that spaces its pulses farther apart than the window, such as 256 ms or 1 s, never qualifies, so the PHY stays powered down for it.

Qualifier states: `Q_IDLE` waits for a first rising edge and moves to `Q_WAIT_LOW`. `Q_WAIT_LOW` waits for the input to go low and moves to `Q_GUARD`. `Q_GUARD` counts the guard time and moves to `Q_ARMED`. `Q_ARMED` waits for a second rising edge and moves to `Q_HIT`. `Q_HIT` holds for one cycle, drives the strobe and returns to `Q_IDLE`. Window expiry returns `Q_WAIT_LOW`, `Q_GUARD` and `Q_ARMED` to `Q_IDLE`. Energy states: `E_OFF` moves to `E_STEADY` on signal-valid. `E_STEADY` moves to `E_COUNTDOWN` when the hold condition is lost. `E_COUNTDOWN` moves back to `E_STEADY` when the hold condition returns, and to `E_OFF` when the drop timer expires. Signal-valid returns any state to `E_STEADY`.

Top module: `nlp_energy_detect`

## Requirements
- R1: While reset is asserted, `energy_on` and `sig_valid` are 0 and both machines are idle.
- R2: A rising edge on `nlp_in` is a cycle where `nlp_in` is 1 and was 0 at the previous clock edge. A rising edge seen while idle opens a qualifying window of WINDOW_TICKS ticks.
- R3: After the first edge, the qualifier waits for `nlp_in` to be 0 and then waits GUARD_TICKS ticks. Rising edges before the guard time ends are not counted.
- R4: A rising edge after the guard time and before the window expires makes `sig_valid` 1 for exactly one cycle, in the cycle after that edge. The qualifier then returns to idle.
- R5: If the window expires with no qualifying edge, the qualifier returns to idle with no strobe, and `energy_on` is unchanged.
- R6: A pulse still high when the guard time ends is not counted. Only a later fall followed by a rise counts.
- R7: `energy_on` is 1 in the cycle after `sig_valid` from any state, and the drop timer restarts from zero.
- R8: With `an_enable`=1, the drop timer runs while `an_detect`=1. Reaching DROP_TICKS drives `energy_on` to 0.
- R9: With `an_enable`=1, `an_detect` going to 0 before expiry cancels and clears the drop timer, and `energy_on` stays 1.
- R10: With `an_enable`=0, the drop timer runs while `link_up`=0 and is cleared while `link_up`=1. DROP_TICKS of absent link drives `energy_on` to 0.
- R11: Pulses spaced farther apart than the window never raise `energy_on`.
- R12: While `energy_on` is 0, it stays 0 regardless of `an_enable`, `an_detect` and `link_up` until `sig_valid` fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nlp_in | input | 1 | Digitised link-pulse level, synchronous to clk |
| an_enable | input | 1 | Auto-negotiation enabled |
| an_detect | input | 1 | Auto-negotiation is in its detection state |
| link_up | input | 1 | Link status |
| sig_valid | output | 1 | One-cycle strobe when a pulse pair qualifies |
| energy_on | output | 1 | Energy-on flag, 1 takes the PHY out of power-down |

## Verification
The bench sends a second edge inside the guard time. A design that skipped the low check or the guard would wake on it. It holds a pulse high across the end of the guard time, which exposes a design that counts levels instead of edges. It spaces pulses beyond the window to expose a window that never closes. It also moves auto-negotiation out of its detection state shortly before the drop period ends, and re-qualifies during a running countdown. A design that failed to clear or restart the drop timer would then drop energy-on early.

// File: rtl/ned_pkg.sv
package ned_pkg;

    typedef enum logic [2:0] {
        Q_IDLE,
        Q_WAIT_LOW,
        Q_GUARD,
        Q_ARMED,
        Q_HIT
    } qual_state_t;

    typedef enum logic [1:0] {
        E_OFF,
        E_STEADY,
        E_COUNTDOWN
    } energy_state_t;

endpackage

// File: rtl/ned_tick_gen.sv
module ned_tick_gen #(
    parameter int CLKS_PER_TICK = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (CLKS_PER_TICK <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int DW = $clog2(CLKS_PER_TICK);
            localparam logic [DW-1:0] LAST = DW'(CLKS_PER_TICK - 1);
            logic [DW-1:0] div_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    div_q <= '0;
                else if (div_q == LAST)
                    div_q <= '0;
                else
                    div_q <= div_q + 1'b1;
            end

            assign tick = (div_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/ned_tick_timer.sv
module ned_tick_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (tick && (cnt_q != LIM_V))
            cnt_q <= cnt_q + 1'b1;
    end

    assign done = (cnt_q == LIM_V);
endmodule

// File: rtl/ned_pulse_qual.sv
module ned_pulse_qual
    import ned_pkg::*;
#(
    parameter int GUARD_TICKS  = 2,
    parameter int WINDOW_TICKS = 64000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic nlp_in,
    output logic sig_valid
);
    qual_state_t state_q, state_d;
    logic        nlp_q;
    logic        rise;
    logic        win_done;
    logic        grd_done;
    logic        win_clr;
    logic        grd_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= Q_IDLE;
            nlp_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            nlp_q   <= nlp_in;
        end
    end

    assign rise    = nlp_in & ~nlp_q;
    assign win_clr = (state_q == Q_IDLE);
    assign grd_clr = (state_q != Q_GUARD);

    ned_tick_timer #(.LIMIT(WINDOW_TICKS)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (win_clr),
        .tick  (tick),
        .done  (win_done)
    );

    ned_tick_timer #(.LIMIT(GUARD_TICKS)) u_grd (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (grd_clr),
        .tick  (tick),
        .done  (grd_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_IDLE: begin
                if (rise)
                    state_d = Q_WAIT_LOW;
            end
            Q_WAIT_LOW: begin
                if (win_done)
                    state_d = Q_IDLE;
                else if (!nlp_in)
                    state_d = Q_GUARD;
            end
            Q_GUARD: begin
                if (win_done)
                    state_d = Q_IDLE;
                else if (grd_done)
                    state_d = Q_ARMED;
            end
            Q_ARMED: begin
                if (win_done)
                    state_d = Q_IDLE;
                else if (rise)
                    state_d = Q_HIT;
            end
            Q_HIT: begin
                state_d = Q_IDLE;
            end
            default: state_d = Q_IDLE;
        endcase
    end

    always_comb begin
        sig_valid = (state_q == Q_HIT);
    end
endmodule

// File: rtl/ned_drop_ctl.sv
module ned_drop_ctl
    import ned_pkg::*;
#(
    parameter int DROP_TICKS = 256000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sig_valid,
    input  logic an_enable,
    input  logic an_detect,
    input  logic link_up,
    output logic energy_on
);
    energy_state_t state_q, state_d;
    logic          hold;
    logic          drop_clr;
    logic          drop_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= E_OFF;
        else
            state_q <= state_d;
    end

    assign hold     = an_enable ? ~an_detect : link_up;
    assign drop_clr = (state_q != E_COUNTDOWN);

    ned_tick_timer #(.LIMIT(DROP_TICKS)) u_drop (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (drop_clr),
        .tick  (tick),
        .done  (drop_done)
    );

    always_comb begin
        state_d = state_q;
        if (sig_valid) begin
            state_d = E_STEADY;
        end else begin
            unique case (state_q)
                E_OFF: state_d = E_OFF;
                E_STEADY: begin
                    if (!hold)
                        state_d = E_COUNTDOWN;
                end
                E_COUNTDOWN: begin
                    if (hold)
                        state_d = E_STEADY;
                    else if (drop_done)
                        state_d = E_OFF;
                end
                default: state_d = E_OFF;
            endcase
        end
    end

    always_comb begin
        energy_on = (state_q != E_OFF);
    end
endmodule

// File: rtl/nlp_energy_detect.sv
module nlp_energy_detect #(
    parameter int CLKS_PER_TICK = 50,
    parameter int GUARD_TICKS   = 2,
    parameter int WINDOW_TICKS  = 64000,
    parameter int DROP_TICKS    = 256000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nlp_in,
    input  logic an_enable,
    input  logic an_detect,
    input  logic link_up,
    output logic sig_valid,
    output logic energy_on
);
    logic tick;

    ned_tick_gen #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    ned_pulse_qual #(
        .GUARD_TICKS  (GUARD_TICKS),
        .WINDOW_TICKS (WINDOW_TICKS)
    ) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .nlp_in    (nlp_in),
        .sig_valid (sig_valid)
    );

    ned_drop_ctl #(.DROP_TICKS(DROP_TICKS)) u_drop (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .sig_valid (sig_valid),
        .an_enable (an_enable),
        .an_detect (an_detect),
        .link_up   (link_up),
        .energy_on (energy_on)
    );
endmodule

// File: rtl/ned_energy_checker.sv
module ned_energy_checker (
    input logic clk,
    input logic rst_n,
    input logic nlp_in,
    input logic sig_valid,
    input logic energy_on
);
    // R1: outputs are low at every edge during reset
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!energy_on && !sig_valid)
                else $error("reset state wrong");
        end
    end

    // R4: strobe lasts exactly one cycle
    p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sig_valid |=> !sig_valid);

    // R4: the accepted edge had the input high
    p_strobe_after_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sig_valid |-> $past(nlp_in));

    // R7: signal-valid always leaves energy-on high
    p_valid_wakes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sig_valid |=> energy_on);

    // R12: energy-on only rises after signal-valid
    p_rise_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(energy_on) |-> $past(sig_valid));

    // R12: off stays off without signal-valid
    p_off_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!energy_on && !sig_valid) |=> !energy_on);
endmodule

bind nlp_energy_detect ned_energy_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .nlp_in    (nlp_in),
    .sig_valid (sig_valid),
    .energy_on (energy_on)
);

// File: tb/sim_nlp_energy_detect.sv
`timescale 1ns/1ps
module sim_nlp_energy_detect;
    localparam int DIV   = 4;
    localparam int GUARD = 2;
    localparam int WIN   = 20;
    localparam int DROP  = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nlp_in = 1'b0;
    logic an_enable = 1'b0;
    logic an_detect = 1'b0;
    logic link_up = 1'b1;
    logic sig_valid;
    logic energy_on;

    int checks = 0;
    int fails = 0;
    int sv_seen = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    nlp_energy_detect #(
        .CLKS_PER_TICK (DIV),
        .GUARD_TICKS   (GUARD),
        .WINDOW_TICKS  (WIN),
        .DROP_TICKS    (DROP)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .nlp_in    (nlp_in),
        .an_enable (an_enable),
        .an_detect (an_detect),
        .link_up   (link_up),
        .sig_valid (sig_valid),
        .energy_on (energy_on)
    );

    // Behavioural reference: phases and elapsed tick counts
    int  edges_since_rst = 0;
    int  phase = 0;          // 0 idle,1 want low,2 guard,3 armed,4 strobe
    int  win_elapsed = 0;
    int  grd_elapsed = 0;
    int  mode = 0;           // 0 off,1 awake,2 awake with drop running
    int  drop_elapsed = 0;
    bit  prev_nlp = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edges_since_rst = 0; phase = 0; win_elapsed = 0; grd_elapsed = 0;
            mode = 0; drop_elapsed = 0; prev_nlp = 1'b0;
        end else begin
            bit t, edge_up, keep, strobe;
            int nphase, nmode;
            t       = ((edges_since_rst % DIV) == DIV - 1);
            edge_up = nlp_in && !prev_nlp;
            strobe  = (phase == 4);
            keep    = an_enable ? !an_detect : link_up;
            nphase  = phase;
            if (phase == 0 && edge_up) nphase = 1;
            else if (phase >= 1 && phase <= 3 && win_elapsed >= WIN) nphase = 0;
            else if (phase == 1 && !nlp_in) nphase = 2;
            else if (phase == 2 && grd_elapsed >= GUARD) nphase = 3;
            else if (phase == 3 && edge_up) nphase = 4;
            else if (phase == 4) nphase = 0;
            nmode = mode;
            if (strobe) nmode = 1;
            else if (mode == 1 && !keep) nmode = 2;
            else if (mode == 2 && keep) nmode = 1;
            else if (mode == 2 && drop_elapsed >= DROP) nmode = 0;
            if (phase == 0) win_elapsed = 0;
            else if (t && win_elapsed < WIN) win_elapsed++;
            if (phase != 2) grd_elapsed = 0;
            else if (t && grd_elapsed < GUARD) grd_elapsed++;
            if (mode != 2) drop_elapsed = 0;
            else if (t && drop_elapsed < DROP) drop_elapsed++;
            phase = nphase;
            mode = nmode;
            prev_nlp = nlp_in;
            edges_since_rst++;
        end
    end

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (sig_valid !== (phase == 4)) begin
                fails++;
                $display("FAIL R4 cycle model: sig_valid=%0b expected %0b at %0t",
                         sig_valid, (phase == 4), $time);
            end
            checks++;
            if (energy_on !== (mode != 0)) begin
                fails++;
                $display("FAIL R7 cycle model: energy_on=%0b expected %0b at %0t",
                         energy_on, (mode != 0), $time);
            end
            if (sig_valid === 1'b1) sv_seen++;
        end
    end

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input int width);
        @(negedge clk); nlp_in = 1'b1;
        wait_cyc(width);
        nlp_in = 1'b0;
    endtask

    task automatic good_pair();
        pulse(2);
        wait_cyc(20);
        pulse(2);
        wait_cyc(5);
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        wait_cyc(200000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        int base;
        wait_cyc(3);
        check(energy_on == 1'b0 && sig_valid == 1'b0, "R1 reset", energy_on, 0);
        @(negedge clk); rst_n = 1'b1;
        wait_cyc(2);
        check(energy_on == 1'b0, "R1 after release", energy_on, 0);

        // R12: side inputs alone never wake it
        an_enable = 1'b1; an_detect = 1'b0; wait_cyc(30);
        an_enable = 1'b0; link_up = 1'b1; wait_cyc(30);
        check(energy_on == 1'b0, "R12 off ignores side inputs", energy_on, 0);

        // R11: pulses spaced beyond the window
        base = sv_seen;
        pulse(3); wait_cyc(100); pulse(3); wait_cyc(100); pulse(3); wait_cyc(100);
        check(energy_on == 1'b0, "R11 slow partner", energy_on, 0);
        check(sv_seen == base, "R2 window closes between slow pulses", sv_seen - base, 0);

        // R3: second edge inside guard time is ignored
        base = sv_seen;
        pulse(2); wait_cyc(2); pulse(2); wait_cyc(100);
        check(energy_on == 1'b0, "R3 edge in guard", energy_on, 0);
        check(sv_seen == base, "R3 no strobe", sv_seen - base, 0);

        // R4: qualifying pair
        an_enable = 1'b1; an_detect = 1'b0;
        base = sv_seen;
        good_pair();
        check(sv_seen == base + 1, "R4 single strobe", sv_seen - base, 1);
        check(energy_on == 1'b1, "R7 wake on valid", energy_on, 1);

        // R9: leaving detection before expiry keeps it on
        an_detect = 1'b1; wait_cyc(120); an_detect = 1'b0; wait_cyc(20);
        an_detect = 1'b1; wait_cyc(120); an_detect = 1'b0; wait_cyc(50);
        check(energy_on == 1'b1, "R9 cancel keeps on", energy_on, 1);

        // R8: sustained detection drops it
        an_detect = 1'b1; wait_cyc(200);
        check(energy_on == 1'b0, "R8 detect timeout", energy_on, 0);
        an_detect = 1'b0; wait_cyc(40);
        check(energy_on == 1'b0, "R12 stays off", energy_on, 0);

        // R6: pulse held high across the guard end
        an_enable = 1'b0; link_up = 1'b1;
        base = sv_seen;
        pulse(2); wait_cyc(2); pulse(30); wait_cyc(5);
        check(energy_on == 1'b0 && sv_seen == base, "R6 held pulse not counted", energy_on, 0);
        pulse(2); wait_cyc(5);
        check(energy_on == 1'b1, "R6 fresh edge counts", energy_on, 1);

        // R10: link loss with auto-negotiation off
        link_up = 1'b0; wait_cyc(100); link_up = 1'b1; wait_cyc(50);
        link_up = 1'b0; wait_cyc(100); link_up = 1'b1; wait_cyc(20);
        check(energy_on == 1'b1, "R10 link return clears timer", energy_on, 1);
        link_up = 1'b0; wait_cyc(200);
        check(energy_on == 1'b0, "R10 link absent timeout", energy_on, 0);

        // R5: lone pulse, window expires
        base = sv_seen;
        pulse(2); wait_cyc(120);
        check(energy_on == 1'b0 && sv_seen == base, "R5 expiry no strobe", sv_seen - base, 0);

        // R7: re-qualifying restarts a running drop timer
        link_up = 1'b0;
        good_pair();
        wait_cyc(100);
        good_pair();
        wait_cyc(110);
        check(energy_on == 1'b1, "R7 valid restarts drop timer", energy_on, 1);
        wait_cyc(100);
        check(energy_on == 1'b0, "R10 drop after restart", energy_on, 0);

        wait_cyc(5);
        summary();
    end
endmodule